// File: doc/BRIEF.md
# Multilevel Buffered Program Controller

This block sequences buffered programming of a flash array that stores two bits per cell as one of four threshold levels. The host fills a write buffer of `WORDS` words of `WORD_W` bits, which is 256 bits and 128 cells by default, through a plain write port. It then raises `prog_start`. From that point the controller works through the whole buffer without host involvement. It raises the gate voltage one stair at a time. At each stair it pulses the cells that are still below target and then verifies them, until every cell reaches its level or the stair limit runs out.

The program-voltage pump can source only a limited current, so cells are pulsed in groups of `GROUP` cells. Groups are visited in ascending address order. A cell leaves the pending set as soon as it verifies, and from then on it receives no further pulses. The analog side is reduced to abstract controls: `pulse_en` with a per-cell `pulse_mask`, `verify_en` with a per-cell `vfy_ok` answer, and `step_up` with the current stair index `gate_step`.

The sequencer has five states:
- IDLE: accepts writes and the start command.
- SCAN: checks the current group for pending cells.
- PULSE: drives the program pulse.
- VERIFY: samples the verify answer.
- SWEEP_END: decides between pass, fail and the next stair.

The transitions are:
- IDLE→SCAN on start.
- SCAN→PULSE when the group has pending cells.
- SCAN→SCAN to skip an empty group.
- SCAN→SWEEP_END after an empty last group.
- PULSE→PULSE while the pulse length runs.
- PULSE→VERIFY when the pulse length is done.
- VERIFY→SCAN for the next group.
- VERIFY→SWEEP_END after the last group.
- SWEEP_END→SCAN for the next stair.
- SWEEP_END→IDLE with pass.
- SWEEP_END→IDLE with fail.

Top module: `mlp_prog_ctrl`

## Requirements
- R1: A write with `wr_en` high in IDLE stores `wr_data` into word `wr_addr`. Cell c is bits [2(c%8)+1 : 2(c%8)] of word c/8. While a group is pulsed or verified, `grp_data` carries the 2-bit codes of that group's cells, with cell i of the group at bits [2i+1:2i].
- R2: The codes map to target levels as 2'b11 = erased (level 0), 2'b10 = level 1, 2'b01 = level 2 and 2'b00 = level 3. A cell whose code is 2'b11 is never set in `pulse_mask`.
- R3: `gate_step` is 0 in the first sweep after a command and rises by one per sweep. `step_up` is high for exactly the one SWEEP_END cycle that precedes each rise.
- R4: Groups of `GROUP` consecutive cells are visited in ascending order, with one SCAN cycle each. A group with pending cells gets `pulse_en` high for `PULSE_LEN` cycles, with `grp_idx` naming the group.
- R5: Every pulse is followed at once by one VERIFY cycle. Cells with `vfy_ok` high in that cycle leave the pending set. `pulse_mask` equals the group's pending cells during a pulse and is zero otherwise.
- R6: When a sweep ends with no pending cell, `pass` is set and `busy` falls on the same edge.
- R7: `busy` is high from the cycle after an accepted `prog_start` until status is posted. `prog_start` and writes are ignored while `busy` is high.
- R8: If `MAX_STEPS` sweeps end with any cell still pending, `fail` is set, `pass` stays low and `busy` falls.
- R9: After reset the controller is in IDLE with `busy`, `pass`, `fail`, `pulse_en`, `verify_en` and `step_up` low, `gate_step` zero, and every buffer cell holding code 2'b11.
- R10: An accepted command clears `pass` and `fail`. Each holds until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | $clog2(WORDS) | Buffer word address |
| wr_data | input | WORD_W | Buffer write data |
| prog_start | input | 1 | Program command |
| vfy_ok | input | GROUP | Per-cell verify answer for the current group |
| busy | output | 1 | Programming in progress |
| pass | output | 1 | Last run finished with all cells at target |
| fail | output | 1 | Last run exhausted the stair limit |
| pulse_en | output | 1 | Program pulse active |
| verify_en | output | 1 | Verify read active |
| step_up | output | 1 | Gate voltage advances one stair |
| gate_step | output | $clog2(MAX_STEPS+1) | Current stair index |
| grp_idx | output | max(1,$clog2(CELLS/GROUP)) | Group being serviced |
| pulse_mask | output | GROUP | Cells of the group receiving the pulse |
| grp_data | output | 2*GROUP | Target codes of the group's cells |

## Verification
The bench builds the block with `GROUP`=16, `MAX_STEPS`=6 and `PULSE_LEN`=2, which gives eight groups per sweep. The short stair limit makes the fail outcome reachable within a few hundred cycles. A two-cycle pulse exercises the pulse-length counter rather than a single-cycle shortcut. The behavioural cell model gives each cell a minimum stair before it moves. Cells therefore need different numbers of sweeps, which exercises skipping of emptied groups, partial masks, and a cell that never moves.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

    localparam int          CELL_BITS   = 2;
    localparam logic [1:0]  CODE_ERASED = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SCAN      = 3'd1,
        ST_PULSE     = 3'd2,
        ST_VERIFY    = 3'd3,
        ST_SWEEP_END = 3'd4
    } mlp_state_e;

endpackage

// File: rtl/mlp_wbuf.sv
module mlp_wbuf
    import mlp_pkg::*;
#(
    parameter  int WORDS    = 16,
    parameter  int WORD_W   = 16,
    parameter  int GROUP    = 16,
    localparam int ADDR_W   = $clog2(WORDS),
    localparam int CELLS    = WORDS * WORD_W / CELL_BITS,
    localparam int NGRP     = CELLS / GROUP,
    localparam int GRP_W    = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int GRP_BITS = GROUP * CELL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_allow,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [GRP_W-1:0]    grp_sel,
    output logic [GRP_BITS-1:0] grp_data,
    output logic [CELLS-1:0]    need_prog
);

    logic [WORD_W-1:0]       mem_q [WORDS];
    logic [WORDS*WORD_W-1:0] flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= '1;
            end
        end else if (wr_en && wr_allow) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_flat
        assign flat[w*WORD_W +: WORD_W] = mem_q[w];
    end

    for (genvar c = 0; c < CELLS; c++) begin : g_need
        assign need_prog[c] = (flat[c*CELL_BITS +: CELL_BITS] != CODE_ERASED);
    end

    assign grp_data = flat[grp_sel*GRP_BITS +: GRP_BITS];

endmodule

// File: rtl/mlp_pend.sv
module mlp_pend #(
    parameter  int CELLS = 128,
    parameter  int GROUP = 16,
    localparam int NGRP  = CELLS / GROUP,
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CELLS-1:0] need_prog,
    input  logic             clr,
    input  logic [GRP_W-1:0] grp_sel,
    input  logic [GROUP-1:0] vfy_ok,
    output logic [GROUP-1:0] grp_pend,
    output logic             any_pend
);

    logic [CELLS-1:0] pend_q;
    logic [CELLS-1:0] pend_d;

    // Each group slice drops its verified cells only when it is the one selected
    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        logic hit;
        assign hit = clr && (grp_sel == GRP_W'(g));
        assign pend_d[g*GROUP +: GROUP] = hit ? (pend_q[g*GROUP +: GROUP] & ~vfy_ok)
                                              :  pend_q[g*GROUP +: GROUP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load) begin
            pend_q <= need_prog;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign grp_pend = pend_q[grp_sel*GROUP +: GROUP];
    assign any_pend = |pend_q;

    AST_PEND_ONLY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pend_q & ~$past(pend_q)) == '0)); // R5

endmodule

// File: rtl/mlp_seq.sv
module mlp_seq
    import mlp_pkg::*;
#(
    parameter  int NGRP      = 8,
    parameter  int MAX_STEPS = 12,
    parameter  int PULSE_LEN = 4,
    localparam int GRP_W     = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int STEP_W    = $clog2(MAX_STEPS + 1),
    localparam int PCNT_W    = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              grp_has,
    input  logic              any_pend,
    output logic              busy,
    output logic              pulse_en,
    output logic              verify_en,
    output logic              step_up,
    output logic              load,
    output logic              clr,
    output logic              wr_allow,
    output logic [GRP_W-1:0]  grp_idx,
    output logic [STEP_W-1:0] gate_step,
    output logic              pass,
    output logic              fail
);

    localparam logic [GRP_W-1:0]  LAST_GRP  = GRP_W'(NGRP - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);
    localparam logic [PCNT_W-1:0] LAST_PCNT = PCNT_W'(PULSE_LEN - 1);

    mlp_state_e        state_q, state_d;
    logic [GRP_W-1:0]  grp_q, grp_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [PCNT_W-1:0] pcnt_q, pcnt_d;
    logic              pass_q, pass_d;
    logic              fail_q, fail_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grp_q   <= '0;
            step_q  <= '0;
            pcnt_q  <= '0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            grp_q   <= grp_d;
            step_q  <= step_d;
            pcnt_q  <= pcnt_d;
            pass_q  <= pass_d;
            fail_q  <= fail_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        grp_d   = grp_q;
        step_d  = step_q;
        pcnt_d  = pcnt_q;
        pass_d  = pass_q;
        fail_d  = fail_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SCAN;
                    grp_d   = '0;
                    step_d  = '0;
                    pass_d  = 1'b0;
                    fail_d  = 1'b0;
                end
            end
            ST_SCAN: begin
                if (grp_has) begin
                    state_d = ST_PULSE;
                    pcnt_d  = '0;
                end else if (grp_q == LAST_GRP) begin
                    state_d = ST_SWEEP_END;
                end else begin
                    grp_d = grp_q + 1'b1;
                end
            end
            ST_PULSE: begin
                if (pcnt_q == LAST_PCNT) begin
                    state_d = ST_VERIFY;
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
            end
            ST_VERIFY: begin
                if (grp_q == LAST_GRP) begin
                    state_d = ST_SWEEP_END;
                end else begin
                    state_d = ST_SCAN;
                    grp_d   = grp_q + 1'b1;
                end
            end
            ST_SWEEP_END: begin
                if (!any_pend) begin
                    state_d = ST_IDLE;
                    pass_d  = 1'b1;
                end else if (step_q == LAST_STEP) begin
                    state_d = ST_IDLE;
                    fail_d  = 1'b1;
                end else begin
                    state_d = ST_SCAN;
                    step_d  = step_q + 1'b1;
                    grp_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        wr_allow  = (state_q == ST_IDLE);
        load      = (state_q == ST_IDLE) && start;
        pulse_en  = (state_q == ST_PULSE);
        verify_en = (state_q == ST_VERIFY);
        clr       = (state_q == ST_VERIFY);
        step_up   = (state_q == ST_SWEEP_END) && any_pend && (step_q != LAST_STEP);
        grp_idx   = grp_q;
        gate_step = step_q;
        pass      = pass_q;
        fail      = fail_q;
    end

    AST_PULSE_THEN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && pcnt_q == LAST_PCNT) |=> (state_q == ST_VERIFY)); // R5
    AST_STEP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (step_q == $past(step_q) || step_q == $past(step_q) + 1'b1)); // R3
    AST_BUSY_ENDS_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pass_q ^ fail_q)); // R7
    AST_GROUPS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && $past(state_q) == ST_SCAN) |-> (grp_q == $past(grp_q) + 1'b1)); // R4
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q)); // R8

endmodule

// File: rtl/mlp_prog_ctrl.sv
module mlp_prog_ctrl
    import mlp_pkg::*;
#(
    parameter  int WORDS     = 16,
    parameter  int WORD_W    = 16,
    parameter  int GROUP     = 16,
    parameter  int MAX_STEPS = 12,
    parameter  int PULSE_LEN = 4,
    localparam int ADDR_W    = $clog2(WORDS),
    localparam int CELLS     = WORDS * WORD_W / CELL_BITS,
    localparam int NGRP      = CELLS / GROUP,
    localparam int GRP_W     = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int STEP_W    = $clog2(MAX_STEPS + 1),
    localparam int GRP_BITS  = GROUP * CELL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                prog_start,
    input  logic [GROUP-1:0]    vfy_ok,
    output logic                busy,
    output logic                pass,
    output logic                fail,
    output logic                pulse_en,
    output logic                verify_en,
    output logic                step_up,
    output logic [STEP_W-1:0]   gate_step,
    output logic [GRP_W-1:0]    grp_idx,
    output logic [GROUP-1:0]    pulse_mask,
    output logic [GRP_BITS-1:0] grp_data
);

    logic             load, clr, wr_allow, any_pend;
    logic [CELLS-1:0] need_prog;
    logic [GROUP-1:0] grp_pend;
    logic [GROUP-1:0] grp_erased;

    mlp_wbuf #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .GROUP  (GROUP)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_allow  (wr_allow),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .grp_sel   (grp_idx),
        .grp_data  (grp_data),
        .need_prog (need_prog)
    );

    mlp_pend #(
        .CELLS (CELLS),
        .GROUP (GROUP)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .need_prog (need_prog),
        .clr       (clr),
        .grp_sel   (grp_idx),
        .vfy_ok    (vfy_ok),
        .grp_pend  (grp_pend),
        .any_pend  (any_pend)
    );

    mlp_seq #(
        .NGRP      (NGRP),
        .MAX_STEPS (MAX_STEPS),
        .PULSE_LEN (PULSE_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (prog_start),
        .grp_has   (|grp_pend),
        .any_pend  (any_pend),
        .busy      (busy),
        .pulse_en  (pulse_en),
        .verify_en (verify_en),
        .step_up   (step_up),
        .load      (load),
        .clr       (clr),
        .wr_allow  (wr_allow),
        .grp_idx   (grp_idx),
        .gate_step (gate_step),
        .pass      (pass),
        .fail      (fail)
    );

    assign pulse_mask = pulse_en ? grp_pend : '0;

    for (genvar i = 0; i < GROUP; i++) begin : g_erased
        assign grp_erased[i] = (grp_data[i*CELL_BITS +: CELL_BITS] == CODE_ERASED);
    end

    AST_NO_ERASED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_en |-> ((pulse_mask & grp_erased) == '0)); // R2
    AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pulse_en && !verify_en && !step_up)); // R7

endmodule

// File: tb/tb_mlp_prog_ctrl.sv
module tb_mlp_prog_ctrl;

    localparam int WORDS     = 16;
    localparam int WORD_W    = 16;
    localparam int GROUP     = 16;
    localparam int MAX_STEPS = 6;
    localparam int PULSE_LEN = 2;
    localparam int CELLS     = WORDS * WORD_W / 2;
    localparam int NGRP      = CELLS / GROUP;
    localparam int PER_WORD  = WORD_W / 2;

    logic                 clk, rst_n, wr_en, prog_start;
    logic [3:0]           wr_addr;
    logic [WORD_W-1:0]    wr_data;
    logic [GROUP-1:0]     vfy_ok;
    logic                 busy, pass, fail, pulse_en, verify_en, step_up;
    logic [2:0]           gate_step;
    logic [2:0]           grp_idx;
    logic [GROUP-1:0]     pulse_mask;
    logic [2*GROUP-1:0]   grp_data;

    mlp_prog_ctrl #(
        .WORDS(WORDS), .WORD_W(WORD_W), .GROUP(GROUP),
        .MAX_STEPS(MAX_STEPS), .PULSE_LEN(PULSE_LEN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_start(prog_start), .vfy_ok(vfy_ok), .busy(busy), .pass(pass), .fail(fail),
        .pulse_en(pulse_en), .verify_en(verify_en), .step_up(step_up), .gate_step(gate_step),
        .grp_idx(grp_idx), .pulse_mask(pulse_mask), .grp_data(grp_data)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 0;
    bit finished = 0;

    logic [WORD_W-1:0] sh [WORDS];
    int  lvl  [CELLS];
    int  sens [CELLS];
    int  erased_hits = 0;
    int  pulse_cnt = 0;
    bit  pulse_d = 0;

    bit          m_busy = 0;
    bit [CELLS-1:0] m_pend;
    bit          e_busy = 0, e_pass = 0, e_fail = 0, e_pulse = 0, e_vfy = 0, e_stepup = 0;
    int          e_step = 0, e_grp = 0;
    logic [GROUP-1:0] e_mask = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] cell_code(int c);
        logic [WORD_W-1:0] w;
        w = sh[c / PER_WORD];
        return 2'(w >> (2 * (c % PER_WORD)));
    endfunction

    function automatic int tgt_of(logic [1:0] code);
        case (code)
            2'b11:   return 0;
            2'b10:   return 1;
            2'b01:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [2*GROUP-1:0] grp_bits(int g);
        logic [2*GROUP-1:0] v;
        v = '0;
        for (int i = 0; i < GROUP; i++) v[2*i +: 2] = cell_code(g*GROUP + i);
        return v;
    endfunction

    function automatic logic [GROUP-1:0] grp_mask(int g);
        logic [GROUP-1:0] v;
        for (int i = 0; i < GROUP; i++) v[i] = m_pend[g*GROUP + i];
        return v;
    endfunction

    // Behavioural array: verify answer and per-pulse level growth
    always_comb begin
        for (int i = 0; i < GROUP; i++) begin
            vfy_ok[i] = lvl[int'(grp_idx)*GROUP + i] >= tgt_of(cell_code(int'(grp_idx)*GROUP + i));
        end
    end

    always @(posedge clk) begin
        if (pulse_en && !pulse_d) begin
            pulse_cnt++;
            for (int i = 0; i < GROUP; i++) begin
                if (pulse_mask[i]) begin
                    if (cell_code(int'(grp_idx)*GROUP + i) == 2'b11) erased_hits++;
                    if (int'(gate_step) >= sens[int'(grp_idx)*GROUP + i] && lvl[int'(grp_idx)*GROUP + i] < 3)
                        lvl[int'(grp_idx)*GROUP + i]++;
                end
            end
        end
        pulse_d = pulse_en;
    end

    // Reference model: cycle sequence of one command
    task automatic model_run();
        bit any;
        m_busy = 1; e_busy = 1; e_pass = 0; e_fail = 0;
        for (int c = 0; c < CELLS; c++) m_pend[c] = (cell_code(c) != 2'b11);
        for (int s = 0; s < MAX_STEPS; s++) begin
            e_step = s;
            for (int g = 0; g < NGRP; g++) begin
                e_grp = g; e_stepup = 0;
                @(posedge clk);
                if (grp_mask(g) != '0) begin
                    e_pulse = 1; e_mask = grp_mask(g);
                    repeat (PULSE_LEN) @(posedge clk);
                    e_pulse = 0; e_mask = '0; e_vfy = 1;
                    @(posedge clk);
                    e_vfy = 0;
                    for (int i = 0; i < GROUP; i++) begin
                        if (lvl[g*GROUP + i] >= tgt_of(cell_code(g*GROUP + i))) m_pend[g*GROUP + i] = 0;
                    end
                end
            end
            any = (m_pend != '0);
            e_stepup = any && (s < MAX_STEPS - 1);
            @(posedge clk);
            e_stepup = 0;
            if (!any) begin
                e_pass = 1; e_busy = 0; m_busy = 0;
                return;
            end
        end
        e_fail = 1; e_busy = 0; m_busy = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && prog_start && !m_busy) model_run();
        end
    end

    // Every-cycle comparison
    always @(negedge clk) begin
        if (rst_n && cmp_on && !finished) begin
            chk(busy === e_busy, "R7 busy", busy, e_busy);
            chk(pass === e_pass, "R6 pass", pass, e_pass);
            chk(fail === e_fail, "R8 fail", fail, e_fail);
            chk(pulse_en === e_pulse, "R4 pulse_en", pulse_en, e_pulse);
            chk(verify_en === e_vfy, "R5 verify_en", verify_en, e_vfy);
            chk(step_up === e_stepup, "R3 step_up", step_up, e_stepup);
            chk(pulse_mask === e_mask, "R5 pulse_mask", pulse_mask, e_mask);
            if (e_busy) chk(int'(gate_step) == e_step, "R3 gate_step", gate_step, e_step);
            if (e_pulse || e_vfy) begin
                chk(int'(grp_idx) == e_grp, "R4 grp_idx", grp_idx, e_grp);
                chk(grp_data === grp_bits(e_grp), "R1 grp_data", grp_data, grp_bits(e_grp));
            end
        end
    end

    task automatic write_word(input int a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'(a); wr_data = d;
        if (!m_busy) sh[a] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic run_cmd();
        for (int c = 0; c < CELLS; c++) lvl[c] = 0;
        pulse_cnt = 0; erased_hits = 0;
        @(negedge clk); prog_start = 1;
        @(negedge clk); prog_start = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL R7 watchdog busy=%0b expected 0", busy);
            summary();
            $finish;
        end
    end

    initial begin
        int bad;
        rst_n = 0; wr_en = 0; prog_start = 0; wr_addr = '0; wr_data = '0;
        for (int w = 0; w < WORDS; w++) sh[w] = '1;
        for (int c = 0; c < CELLS; c++) begin lvl[c] = 0; sens[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !pass && !fail, "R9 status", {busy, pass, fail}, 0);
        chk(!pulse_en && !verify_en && !step_up, "R9 controls", {pulse_en, verify_en, step_up}, 0);
        chk(gate_step == 0, "R9 gate_step", gate_step, 0);
        cmp_on = 1;

        // Erased buffer after reset: one sweep, no pulses (R9, R2, R6)
        run_cmd();
        chk(pass == 1, "R6 pass erased", pass, 1);
        chk(pulse_cnt == 0, "R9 R2 erased buffer pulses", pulse_cnt, 0);
        chk(gate_step == 0, "R3 single sweep", gate_step, 0);

        // Mixed codes, varied stair sensitivity (R1, R2, R4, R5)
        for (int w = 0; w < WORDS; w++) write_word(w, 16'h1B6E ^ 16'(w * 16'h2357));
        for (int c = 0; c < CELLS; c++) sens[c] = c % 3;
        run_cmd();
        chk(pass == 1 && fail == 0, "R6 mixed pass", {pass, fail}, 2);
        bad = 0;
        for (int c = 0; c < CELLS; c++) if (lvl[c] != tgt_of(cell_code(c))) bad++;
        chk(bad == 0, "R5 cells at target", bad, 0);
        chk(erased_hits == 0, "R2 erased never pulsed", erased_hits, 0);

        // All level 3, write and start while busy ignored (R7)
        for (int w = 0; w < WORDS; w++) write_word(w, 16'h0000);
        for (int c = 0; c < CELLS; c++) sens[c] = c % 2;
        for (int c = 0; c < CELLS; c++) lvl[c] = 0;
        pulse_cnt = 0;
        @(negedge clk); prog_start = 1;
        @(negedge clk); prog_start = 0;
        repeat (20) @(negedge clk);
        write_word(5, 16'hFFFF);
        @(negedge clk); prog_start = 1;
        @(negedge clk); prog_start = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(pass == 1, "R7 run unaffected", pass, 1);
        bad = 0;
        for (int i = 0; i < PER_WORD; i++) if (lvl[5*PER_WORD + i] != 3) bad++;
        chk(bad == 0, "R7 busy write ignored", bad, 0);

        // One stuck cell exhausts the stair limit (R8)
        for (int w = 0; w < WORDS; w++) write_word(w, 16'hFFFE);
        for (int c = 0; c < CELLS; c++) sens[c] = 0;
        sens[40] = 99;
        run_cmd();
        chk(fail == 1 && pass == 0, "R8 fail posted", {pass, fail}, 1);
        chk(busy == 0, "R8 busy dropped", busy, 0);
        chk(lvl[40] == 0 && lvl[48] == 1, "R8 stuck cell", lvl[40], 0);
        chk(int'(gate_step) == MAX_STEPS - 1, "R3 final stair", gate_step, MAX_STEPS - 1);

        // Next command clears fail (R10)
        for (int w = 0; w < WORDS; w++) write_word(w, 16'hFFFF);
        sens[40] = 0;
        run_cmd();
        chk(fail == 0 && pass == 1, "R10 status replaced", {pass, fail}, 2);
        chk(gate_step == 0, "R3 stair restarts", gate_step, 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule